// File: doc/BRIEF.md
# Quadrature Encoder Speed Sampler

This block turns the two phase signals of an incremental quadrature encoder on one motor into a periodic speed measurement. Both phases are first retimed into the clock domain. A small state machine then follows their Gray-coded sequence and gives one count per phase change. The count is positive in one rotation direction and negative in the other.

The counts are summed over a window with a fixed number of clock cycles. With the default of 125000 cycles at 125 MHz, one sample is produced every millisecond, which matches a 1 ms control loop. When a window closes, the net count is converted to sign-magnitude form: the top bit holds the direction and the magnitude saturates. The result goes into a holding register, and the running sum starts again from zero in the same cycle.

A processor reads the held word, and a sticky "fresh sample" flag, through a small memory-mapped read port with a fixed latency. The processor can poll the flag and then fetch the speed once per control period.

Decoder states, named by the retimed {A,B} level: `PH_00`, `PH_10`, `PH_11`, `PH_01`. The forward ring is PH_00 → PH_10 → PH_11 → PH_01 → PH_00, which is the order where A leads B. Each cycle the decoder takes one of four transitions:
- `STEP_FWD`: one step along the forward ring, count +1.
- `STEP_REV`: one step against the ring, count −1.
- `STEP_HOLD`: no change.
- `STEP_SKIP`: both phases changed at once. No count is made, and the state moves to the new level.

Top module: `qenc_speed_sampler`

## Requirements
- R1: After reset, a read of address 0 and a read of address 1 both return 0, and `readdata` is 0.
- R2: With phases {A,B} stepping 00→10→11→01→00 (A leads B), each change adds one to the window count. The sample word then has sign bit MAG_W = 0 and magnitude bits [MAG_W-1:0] equal to the number of changes.
- R3: With phases stepping 00→01→11→10→00 (B leads A), each change subtracts one. The sample has sign bit MAG_W = 1 and the magnitude equals the number of changes.
- R4: A cycle in which both retimed phases change together adds nothing to the count. Later single changes are judged from the new level.
- R5: A new sample is latched once every WINDOW_CYCLES clock cycles, the first one WINDOW_CYCLES cycles after reset. Between latches the held word does not change.
- R6: A phase change decoded in the last cycle of a window goes into that window's sample, and the running sum restarts from zero. No change is lost or counted twice across windows.
- R7: When the magnitude of the net count exceeds 2^MAG_W−1, the magnitude reads 2^MAG_W−1 in either direction, with the correct sign.
- R8: A window with zero net count gives the all-zero word, with sign bit 0.
- R9: `readdata` shows the addressed value in the cycle after `read` is high, and is 0 in any cycle not following a read. Address 0 holds the speed word in bits [MAG_W:0]; address 1 holds the fresh flag in bit 0. Every other address and bit reads 0.
- R10: Reads at any address in the middle of a window leave that window's sample unchanged.
- R11: The fresh flag sets when a sample is latched and clears on a read of address 0. A read of address 1 leaves it set. A latch in the same cycle as a clearing read leaves it set.
- R12: Each phase input passes through a two-stage synchroniser, so a pin change takes effect on the count two clock cycles after it is first sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| address | input | ADDR_W | Read address (0 speed, 1 status) |
| read | input | 1 | Read strobe |
| readdata | output | DATA_W | Read data, one cycle after the strobe |

## Verification
The bench builds the block with WINDOW_CYCLES = 64, MAG_W = 4, DATA_W = 16 and ADDR_W = 2.

The short window lets a single stimulus burst fit inside one window. It also means many window boundaries pass within a few thousand cycles, so changes land in the boundary cycle often.

The 4-bit magnitude means a burst of twenty steps drives the count past 15 in both directions, which reaches saturation. A behavioural model of the pin-to-`readdata` path is compared with the design on every clock.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Phase level of the retimed {A,B} pair; value equals position on the forward ring.
    typedef enum logic [1:0] {
        PH_00 = 2'd0,
        PH_10 = 2'd1,
        PH_11 = 2'd2,
        PH_01 = 2'd3
    } phase_e;

    // Transition taken by the decoder in one cycle.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_FWD  = 2'd1,
        STEP_REV  = 2'd2,
        STEP_SKIP = 2'd3
    } step_e;

    function automatic phase_e phase_of(input logic a, input logic b);
        phase_e p;
        unique case ({a, b})
            2'b00:   p = PH_00;
            2'b10:   p = PH_10;
            2'b11:   p = PH_11;
            default: p = PH_01;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[s] <= '0;
                    else     pipe_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[s] <= '0;
                    else     pipe_q[s] <= pipe_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = pipe_q[STAGES-1];

    // R12: the output only ever repeats what the previous stage held a cycle earlier
    p_sync_shift_r12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (dout == $past(pipe_q[STAGES-2 < 0 ? 0 : STAGES-2])) || (STAGES < 2));

endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
    import qenc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ph_a,
    input  logic ph_b,
    output logic cnt_up,
    output logic cnt_dn
);

    phase_e phase_q;
    phase_e phase_now;
    step_e  step;

    assign phase_now = phase_of(ph_a, ph_b);

    // State register: always follows the retimed level, including after a skip.
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_00;
        else     phase_q <= phase_now;
    end

    // Output process: classify the move from the held state to the present level.
    always_comb begin
        step = STEP_HOLD;
        unique case (phase_q)
            PH_00: begin
                if      (phase_now == PH_10) step = STEP_FWD;
                else if (phase_now == PH_01) step = STEP_REV;
                else if (phase_now == PH_11) step = STEP_SKIP;
                else                         step = STEP_HOLD;
            end
            PH_10: begin
                if      (phase_now == PH_11) step = STEP_FWD;
                else if (phase_now == PH_00) step = STEP_REV;
                else if (phase_now == PH_01) step = STEP_SKIP;
                else                         step = STEP_HOLD;
            end
            PH_11: begin
                if      (phase_now == PH_01) step = STEP_FWD;
                else if (phase_now == PH_10) step = STEP_REV;
                else if (phase_now == PH_00) step = STEP_SKIP;
                else                         step = STEP_HOLD;
            end
            PH_01: begin
                if      (phase_now == PH_00) step = STEP_FWD;
                else if (phase_now == PH_11) step = STEP_REV;
                else if (phase_now == PH_10) step = STEP_SKIP;
                else                         step = STEP_HOLD;
            end
            default: step = STEP_HOLD;
        endcase
    end

    assign cnt_up = (step == STEP_FWD);
    assign cnt_dn = (step == STEP_REV);

    // R4: a change of both phases between two cycles never produces a count
    p_skip_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (($past(ph_a) != ph_a) && ($past(ph_b) != ph_b)) |-> !(cnt_up || cnt_dn));

    // R2: a forward count follows a change of exactly one phase
    p_fwd_single_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_up |-> (($past(ph_a) != ph_a) != ($past(ph_b) != ph_b)));

    // R3: a reverse count follows a change of exactly one phase
    p_rev_single_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_dn |-> (($past(ph_a) != ph_a) != ($past(ph_b) != ph_b)));

endmodule

// File: rtl/qenc_window.sv
module qenc_window #(
    parameter int WINDOW_CYCLES = 125000,
    parameter int MAG_W         = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cnt_up,
    input  logic           cnt_dn,
    output logic           win_tick,
    output logic [MAG_W:0] speed_word
);

    localparam int CNT_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WINDOW_CYCLES - 1);
    localparam int ACC_W = MAG_W + 2;
    localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((64'd1 << MAG_W) - 64'd1);
    localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM;

    logic [CNT_W-1:0]        wcnt_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] step_val;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] clamped;
    logic [MAG_W-1:0]        mag;
    logic                    neg;
    logic [MAG_W:0]          word_q;

    assign win_tick = (wcnt_q == LAST_CNT);

    always_comb begin
        if (cnt_up)      step_val = ACC_W'(1);
        else if (cnt_dn) step_val = -ACC_W'(1);
        else             step_val = '0;
        sum = acc_q + step_val;
        if (sum > POS_LIM)      clamped = POS_LIM;
        else if (sum < NEG_LIM) clamped = NEG_LIM;
        else                    clamped = sum;
        neg = clamped[ACC_W-1];
        mag = neg ? MAG_W'(-clamped) : MAG_W'(clamped);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= '0;
            acc_q  <= '0;
            word_q <= '0;
        end else if (win_tick) begin
            wcnt_q <= '0;
            acc_q  <= '0;
            word_q <= {neg, mag};
        end else begin
            wcnt_q <= wcnt_q + CNT_W'(1);
            acc_q  <= clamped;
        end
    end

    assign speed_word = word_q;

    // R6: the running sum restarts from zero right after a window closes
    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        win_tick |=> (acc_q == '0));

    // R7: the running sum never leaves the representable magnitude range
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_q <= POS_LIM) && (acc_q >= NEG_LIM));

    // R5: the held word changes only on a window close
    p_word_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !win_tick |=> $stable(speed_word));

    // R5: window closes are never back to back
    p_tick_spacing_r5: assert property (@(posedge clk) disable iff (rst)
        win_tick |=> !win_tick);

    // R8: a zero magnitude never carries the negative sign
    p_zero_positive_r8: assert property (@(posedge clk) disable iff (rst)
        (speed_word[MAG_W-1:0] == '0) |-> !speed_word[MAG_W]);

endmodule

// File: rtl/qenc_readport.sv
module qenc_readport #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2,
    parameter int SPD_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_tick,
    input  logic [SPD_W-1:0]  speed_word,
    input  logic [ADDR_W-1:0] address,
    input  logic              read,
    output logic [DATA_W-1:0] readdata
);

    localparam logic [ADDR_W-1:0] ADDR_SPEED  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_STATUS = ADDR_W'(1);

    logic              fresh_q;
    logic [DATA_W-1:0] rd_d;
    logic [DATA_W-1:0] rd_q;
    logic              clr_req;

    assign clr_req = read && (address == ADDR_SPEED);

    always_comb begin
        rd_d = '0;
        if (read) begin
            if (address == ADDR_SPEED)       rd_d[SPD_W-1:0] = speed_word;
            else if (address == ADDR_STATUS) rd_d[0]         = fresh_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fresh_q <= 1'b0;
            rd_q    <= '0;
        end else begin
            rd_q <= rd_d;
            if (win_tick)     fresh_q <= 1'b1;
            else if (clr_req) fresh_q <= 1'b0;
        end
    end

    assign readdata = rd_q;

    // R9: no read strobe, no data in the following cycle
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !read |=> (readdata == '0));

    // R11: a latch always leaves the fresh flag set
    p_fresh_set_r11: assert property (@(posedge clk) disable iff (rst)
        win_tick |=> fresh_q);

    // R11: a speed read without a latch clears the flag
    p_fresh_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !win_tick) |=> !fresh_q);

endmodule

// File: rtl/qenc_speed_sampler.sv
module qenc_speed_sampler #(
    parameter int WINDOW_CYCLES = 125000,
    parameter int MAG_W         = 12,
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic [ADDR_W-1:0] address,
    input  logic              read,
    output logic [DATA_W-1:0] readdata
);

    localparam int SPD_W = MAG_W + 1;

    logic [1:0]       ph_sync;
    logic             cnt_up;
    logic             cnt_dn;
    logic             win_tick;
    logic [SPD_W-1:0] speed_word;

    qenc_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({enc_a, enc_b}),
        .dout (ph_sync)
    );

    qenc_decoder u_dec (
        .clk    (clk),
        .rst    (rst),
        .ph_a   (ph_sync[1]),
        .ph_b   (ph_sync[0]),
        .cnt_up (cnt_up),
        .cnt_dn (cnt_dn)
    );

    qenc_window #(
        .WINDOW_CYCLES (WINDOW_CYCLES),
        .MAG_W         (MAG_W)
    ) u_win (
        .clk        (clk),
        .rst        (rst),
        .cnt_up     (cnt_up),
        .cnt_dn     (cnt_dn),
        .win_tick   (win_tick),
        .speed_word (speed_word)
    );

    qenc_readport #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SPD_W  (SPD_W)
    ) u_port (
        .clk        (clk),
        .rst        (rst),
        .win_tick   (win_tick),
        .speed_word (speed_word),
        .address    (address),
        .read       (read),
        .readdata   (readdata)
    );

    // R10: a read strobe never coincides with a count being dropped or altered
    p_read_no_disturb_r10: assert property (@(posedge clk) disable iff (rst)
        (read && !win_tick) |=> $stable(speed_word));

endmodule

// File: tb/qenc_speed_sampler_test.sv
module qenc_speed_sampler_test;

    localparam int W     = 64;
    localparam int MAG_W = 4;
    localparam int DW    = 16;
    localparam int AW    = 2;
    localparam int MAXM  = (1 << MAG_W) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enc_a = 1'b0;
    logic          enc_b = 1'b0;
    logic [AW-1:0] address = '0;
    logic          read = 1'b0;
    logic [DW-1:0] readdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    qenc_speed_sampler #(
        .WINDOW_CYCLES (W),
        .MAG_W         (MAG_W),
        .DATA_W        (DW),
        .ADDR_W        (AW),
        .SYNC_STAGES   (2)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .address  (address),
        .read     (read),
        .readdata (readdata)
    );

    // ring position of a level, forward order 00,10,11,01
    function automatic int ring(input bit a, input bit b);
        if (!a && !b) return 0;
        if (a && !b)  return 1;
        if (a && b)   return 2;
        return 3;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_in[$];
    int m_prev;
    int m_acc;
    int m_cyc;
    int m_hold;
    int m_fresh;
    int m_rd;

    always @(posedge clk) begin
        if (rst) begin
            m_in = '{0, 0};
            m_prev = 0; m_acc = 0; m_cyc = 0;
            m_hold = 0; m_fresh = 0; m_rd = 0;
        end else begin
            int lvl, d, s, wd;
            bit close;
            lvl = m_in.pop_front();
            m_in.push_back(ring(enc_a, enc_b));
            d = 0;
            if (lvl == (m_prev + 1) % 4) d = 1;
            else if (lvl == (m_prev + 3) % 4) d = -1;
            m_prev = lvl;
            s = m_acc + d;
            if (s > MAXM) s = MAXM;
            if (s < -MAXM) s = -MAXM;
            m_rd = 0;
            if (read && address == 0) m_rd = m_hold;
            if (read && address == 1) m_rd = m_fresh;
            close = (m_cyc == W - 1);
            if (close) begin
                wd = (s < 0) ? ((1 << MAG_W) | (-s)) : s;
                m_hold = wd;
                m_acc = 0;
                m_cyc = 0;
                m_fresh = 1;
            end else begin
                m_acc = s;
                m_cyc++;
                if (read && address == 0) m_fresh = 0;
            end
        end
    end

    // every-cycle comparison of the read data (R5, R6, R9, R12 timing)
    always @(negedge clk) begin
        if (!rst && !done) chk("R9 cycle compare", int'(readdata), m_rd);
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_read(input int a, output int v);
        @(negedge clk);
        read = 1'b1;
        address = AW'(a);
        @(negedge clk);
        read = 1'b0;
        v = int'(readdata);
    endtask

    task automatic step(input int dir, input int gap);
        int p;
        @(negedge clk);
        if (dir == 0) begin
            enc_a = ~enc_a;
            enc_b = ~enc_b;
        end else begin
            p = (ring(enc_a, enc_b) + (dir > 0 ? 1 : 3)) % 4;
            enc_a = (p == 1 || p == 2);
            enc_b = (p == 2 || p == 3);
        end
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic wait_sample(output int v);
        int s;
        s = 0;
        for (int i = 0; i < 400; i++) begin
            do_read(1, s);
            if (s[0]) break;
        end
        if (!s[0]) chk("R5 sample timeout", 0, 1);
        do_read(0, v);
    endtask

    task automatic finish_up;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        int v, acc_sum;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 readdata after reset", int'(readdata), 0);
        do_read(0, v); chk("R1 speed after reset", v, 0);
        do_read(1, v); chk("R1 status after reset", v, 0);

        // R11: flag semantics
        for (int i = 0; i < 200; i++) begin
            do_read(1, v);
            if (v[0]) break;
        end
        chk("R11 flag set after latch", v, 1);
        do_read(1, v); chk("R11 status read keeps flag", v, 1);
        do_read(0, v);
        do_read(1, v); chk("R11 speed read clears flag", v, 0);

        // R2 forward
        wait_sample(v);
        for (int i = 0; i < 6; i++) step(1, 2);
        wait_sample(v); chk("R2 forward six", v, 6);

        // R3 reverse
        for (int i = 0; i < 5; i++) step(-1, 2);
        wait_sample(v); chk("R3 reverse five", v, (1 << MAG_W) | 5);

        // R8 zero net
        for (int i = 0; i < 3; i++) step(1, 2);
        for (int i = 0; i < 3; i++) step(-1, 2);
        wait_sample(v); chk("R8 zero net", v, 0);

        // R4 simultaneous change ignored
        for (int i = 0; i < 4; i++) step(1, 2);
        step(0, 2);
        for (int i = 0; i < 2; i++) step(1, 2);
        wait_sample(v); chk("R4 skip ignored", v, 6);

        // R7 saturation both directions
        for (int i = 0; i < 20; i++) step(1, 2);
        wait_sample(v); chk("R7 positive saturation", v, MAXM);
        for (int i = 0; i < 20; i++) step(-1, 2);
        wait_sample(v); chk("R7 negative saturation", v, (1 << MAG_W) | MAXM);

        // R10 reads mid window
        for (int i = 0; i < 7; i++) begin
            step(1, 2);
            do_read(i % 2, acc_sum);
        end
        wait_sample(v); chk("R10 reads do not disturb", v, 7);

        // R6 changes spread across window boundaries
        acc_sum = 0;
        fork
            begin
                for (int i = 0; i < 24; i++) step(1, 6);
            end
            begin
                for (int k = 0; k < 3; k++) begin
                    int sv;
                    wait_sample(sv);
                    acc_sum += sv;
                end
            end
        join
        chk("R6 nothing lost across windows", acc_sum, 24);

        // R5 quiet window after activity
        wait_sample(v); chk("R5 idle window", v, 0);

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule